// File: doc/BRIEF.md
# Consumer S/PDIF Transmitter

This block turns a stream of 16-bit stereo PCM sample pairs into a consumer-format IEC 60958 line signal on one output pin. Each left/right pair becomes one frame of two 32-slot subframes. Frames are grouped into 192-frame blocks, and every slot is sent with biphase-mark coding. A separate clock divider supplies `cell_en_i`, which pulses once per half bit-cell. One sample frame therefore takes 128 enabled cycles.

The host writes the validity bit, the first four channel-status bits and the category byte. The block reads these fields live, at the moment each bit leaves. A rate select marks the stream as 48 kHz or 44.1 kHz in the sampling-frequency status bits. Samples arrive through a ready/valid handshake into a single holding register. A pair that arrives in the last half-cell of a frame goes straight into the next frame. If no pair is waiting when a frame starts, that frame carries digital silence.

Top module: `spdif_tx`

## Requirements
- R1: While `rst_ni` is low, `spdif_o` is 0 and `sample_ready_o` is 1. The first frame after reset is frame 0 of a block and carries zero samples.
- R2: Every data cell (slots 4 to 31) inverts the line at its start. For a 1, it inverts the line again at mid-cell. Sample bits occupy slots 12 to 27, LSB first.
- R3: Slots 0 to 3 carry a preamble as eight half-cells. For a line level of 0 before the preamble, the patterns are: B = 11101000 on the left subframe of block frame 0, M = 11100010 on every other left subframe, and W = 11100100 on every right subframe. The pattern is inverted when the level before it is 1. Frames are numbered modulo 192.
- R4: Slots 4 to 11 carry 0 and slot 29 (user) carries 0. Slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R5: Slot 28 of both subframes carries `validity_i`.
- R6: Slot 30 of both subframes of block frame f carries channel-status bit f, built as follows:
  - bits 0 to 3 are `cs_mode_i[f]`;
  - bits 8 to 15 are `cs_category_i[f-8]`;
  - bit 25 is `rate_48k_i`, so bits 24 to 27 read 0,1,0,0 for 48 kHz and all zero for 44.1 kHz;
  - every other bit is 0.
- R7: `sample_ready_o` is 1 exactly when the one-pair holding register is empty. An accepted pair is sent in the next frame that starts after acceptance. This includes a pair accepted in the same cycle as the frame's last half-cell, which is sent in the frame that follows at once.
- R8: A frame that starts with no pair pending carries zero in both sample fields.
- R9: `spdif_o` changes only on clock edges where `cell_en_i` is 1, and each such edge advances exactly one half-cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_en_i | input | 1 | Half bit-cell enable |
| sample_valid_i | input | 1 | Sample pair offered |
| sample_ready_o | output | 1 | Holding register empty |
| sample_left_i | input | 16 | Left sample |
| sample_right_i | input | 16 | Right sample |
| validity_i | input | 1 | Validity bit for every subframe |
| cs_mode_i | input | 4 | Channel-status bits 0 to 3 |
| cs_category_i | input | 8 | Channel-status bits 8 to 15 |
| rate_48k_i | input | 1 | 1: 48 kHz, 0: 44.1 kHz |
| spdif_o | output | 1 | Biphase-mark coded line |

## Verification
Sample acceptance and the frame rollover can fall on the same clock edge. At that edge the holding register is empty and a new pair must skip it and go straight into the next frame. The bench lets the buffer run dry for many frames. It then raises valid only in the cycle before the enabled edge that ends frame 20. The bench's own encoder model predicts every half-cell of the following frame with that pair in it, and any mismatch in the sample slots is reported against R7. The underrun frames before that point are judged against zero samples under R8.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int SLOT_W     = 5;
  localparam int PRE_SLOTS  = 4;
  localparam int SMP_SLOT   = 12;
  localparam int VAL_SLOT   = 28;
  localparam int CS_SLOT    = 30;
  localparam int PAR_SLOT   = 31;
  localparam int CS_CAT_LO  = 8;
  localparam int CS_FS_BIT  = 25;

  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_e;

  // half-cell levels for a preamble that starts from line level 0
  function automatic logic [7:0] pre_pattern(pre_e p);
    case (p)
      PRE_B:   return 8'b1110_1000;
      PRE_M:   return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/spdif_tx_seq.sv
module spdif_tx_seq
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_LEN = 192,
  localparam int FW = $clog2(BLOCK_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cell_en_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                half_o,
  output logic [SLOT_W-1:0]   slot_o,
  output logic                rsub_o,
  output logic [FW-1:0]       frame_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  logic                half_q, rsub_q, full_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [FW-1:0]       frame_q;
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q, act_l_q, act_r_q;
  logic                accept, frame_end;

  assign ready_o   = ~full_q;
  assign accept    = valid_i & ready_o;
  assign frame_end = cell_en_i & half_q & rsub_q & (slot_q == SLOT_W'(PAR_SLOT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      slot_q  <= '0;
      rsub_q  <= 1'b0;
      frame_q <= '0;
    end else if (cell_en_i) begin
      half_q <= ~half_q;
      if (half_q) begin
        slot_q <= slot_q + 1'b1;
        if (slot_q == SLOT_W'(PAR_SLOT)) rsub_q <= ~rsub_q;
      end
      if (frame_end) frame_q <= (frame_q == FW'(BLOCK_LEN - 1)) ? '0 : frame_q + 1'b1;
    end
  end

  // one-pair holding register; a pair arriving at the frame edge bypasses it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      act_l_q  <= '0;
      act_r_q  <= '0;
    end else if (frame_end) begin
      full_q  <= 1'b0;
      act_l_q <= full_q ? hold_l_q : (accept ? left_i  : '0);
      act_r_q <= full_q ? hold_r_q : (accept ? right_i : '0);
    end else if (accept) begin
      full_q   <= 1'b1;
      hold_l_q <= left_i;
      hold_r_q <= right_i;
    end
  end

  assign half_o   = half_q;
  assign slot_o   = slot_q;
  assign rsub_o   = rsub_q;
  assign frame_o  = frame_q;
  assign sample_o = rsub_q ? act_r_q : act_l_q;

  assert_full_not_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !frame_end) |=> !ready_o);
  assert_ready_after_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> ready_o);
  assert_block_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && frame_q == FW'(BLOCK_LEN - 1)) |=> (frame_q == '0));
endmodule

// File: rtl/spdif_tx_slot.sv
module spdif_tx_slot
  import spdif_tx_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                rsub_i,
  input  logic [FW-1:0]       frame_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                validity_i,
  input  logic [3:0]          cs_mode_i,
  input  logic [7:0]          cs_cat_i,
  input  logic                rate_48k_i,
  output logic                bit_o,
  output pre_e                pre_o
);
  logic       cs, parity;
  logic [3:0] smp_idx;

  always_comb begin
    cs = 1'b0;
    if (frame_i < FW'(4))
      cs = cs_mode_i[frame_i[1:0]];
    else if (frame_i >= FW'(CS_CAT_LO) && frame_i < FW'(CS_CAT_LO + 8))
      cs = cs_cat_i[frame_i[2:0]];
    else if (frame_i == FW'(CS_FS_BIT))
      cs = rate_48k_i;
  end

  assign parity  = ^sample_i ^ validity_i ^ cs;
  assign smp_idx = 4'(slot_i - SLOT_W'(SMP_SLOT));

  always_comb begin
    if (slot_i >= SLOT_W'(SMP_SLOT) && slot_i < SLOT_W'(SMP_SLOT + SAMPLE_W))
      bit_o = sample_i[smp_idx];
    else if (slot_i == SLOT_W'(VAL_SLOT)) bit_o = validity_i;
    else if (slot_i == SLOT_W'(CS_SLOT))  bit_o = cs;
    else if (slot_i == SLOT_W'(PAR_SLOT)) bit_o = parity;
    else                                  bit_o = 1'b0;
  end

  assign pre_o = rsub_i ? PRE_W : ((frame_i == '0) ? PRE_B : PRE_M);
endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc
  import spdif_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_en_i,
  input  logic              half_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  pre_e              pre_i,
  input  logic              bit_i,
  output logic              line_o
);
  logic       line_q, base_q, base_eff, in_pre, sub_start;
  logic [2:0] pidx;
  logic [7:0] pat;

  assign in_pre    = slot_i < SLOT_W'(PRE_SLOTS);
  assign sub_start = (slot_i == '0) && !half_i;
  assign pidx      = {slot_i[1:0], half_i};
  assign pat       = pre_pattern(pre_i);
  // preamble polarity follows the level left by the previous cell
  assign base_eff  = sub_start ? line_q : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      base_q <= 1'b0;
    end else if (cell_en_i) begin
      if (sub_start) base_q <= line_q;
      if (in_pre)       line_q <= pat[3'd7 - pidx] ^ base_eff;
      else if (!half_i) line_q <= ~line_q;
      else              line_q <= line_q ^ bit_i;
    end
  end

  assign line_o = line_q;

  assert_cell_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_en_i && !half_i && !in_pre) |=> (line_q != $past(line_q)));
  assert_line_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_en_i |=> $stable(line_q));
  assert_subframe_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_en_i && half_i && slot_i == SLOT_W'(PAR_SLOT)) |=> (line_q == base_q));
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_LEN = 192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cell_en_i,
  input  logic                sample_valid_i,
  output logic                sample_ready_o,
  input  logic [SAMPLE_W-1:0] sample_left_i,
  input  logic [SAMPLE_W-1:0] sample_right_i,
  input  logic                validity_i,
  input  logic [3:0]          cs_mode_i,
  input  logic [7:0]          cs_category_i,
  input  logic                rate_48k_i,
  output logic                spdif_o
);
  localparam int FW = $clog2(BLOCK_LEN);

  logic                half, rsub, bit_v;
  logic [SLOT_W-1:0]   slot;
  logic [FW-1:0]       frame;
  logic [SAMPLE_W-1:0] sample;
  pre_e                pre;

  spdif_tx_seq #(.BLOCK_LEN(BLOCK_LEN)) i_seq (
    .clk_i, .rst_ni, .cell_en_i,
    .valid_i(sample_valid_i), .ready_o(sample_ready_o),
    .left_i(sample_left_i), .right_i(sample_right_i),
    .half_o(half), .slot_o(slot), .rsub_o(rsub), .frame_o(frame), .sample_o(sample)
  );

  spdif_tx_slot #(.FW(FW)) i_slot (
    .slot_i(slot), .rsub_i(rsub), .frame_i(frame), .sample_i(sample),
    .validity_i, .cs_mode_i, .cs_cat_i(cs_category_i), .rate_48k_i,
    .bit_o(bit_v), .pre_o(pre)
  );

  spdif_tx_bmc i_bmc (
    .clk_i, .rst_ni, .cell_en_i, .half_i(half), .slot_i(slot),
    .pre_i(pre), .bit_i(bit_v), .line_o(spdif_o)
  );
endmodule

// File: tb/test_spdif_tx.sv
module test_spdif_tx;
  logic        clk = 1'b0;
  logic        rst_n, cell_en, s_valid, s_ready, validity, rate48, spdif;
  logic [15:0] s_left, s_right;
  logic [3:0]  cs_mode;
  logic [7:0]  cs_cat;

  always #5 clk = ~clk;

  spdif_tx i_spdif_tx (
    .clk_i(clk), .rst_ni(rst_n), .cell_en_i(cell_en),
    .sample_valid_i(s_valid), .sample_ready_o(s_ready),
    .sample_left_i(s_left), .sample_right_i(s_right),
    .validity_i(validity), .cs_mode_i(cs_mode), .cs_category_i(cs_cat),
    .rate_48k_i(rate48), .spdif_o(spdif)
  );

  // stimulus vectors {left, right}; expected line levels come from the model below
  localparam int NTBL = 8;
  localparam logic [31:0] TBL [NTBL] = '{
    32'h0001_8000, 32'hFFFF_0000, 32'h1234_ABCD, 32'h5555_AAAA,
    32'h7FFF_8001, 32'h0F0F_F0F0, 32'hC3A5_5A3C, 32'h8421_1248};
  localparam logic [31:0] COL_PAIR = 32'hBEEF_6A19;
  localparam int NFRAMES = 222;
  localparam int COL_AT  = 20;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic bit cs_bit(int f, logic [3:0] m, logic [7:0] c, logic r);
    if (f >= 0 && f <= 3)  return m[f];
    if (f >= 8 && f <= 15) return c[f-8];
    if (f == 25)           return r;
    return 1'b0;
  endfunction

  function automatic logic [127:0] build(int f, logic [15:0] l, logic [15:0] r,
      logic v, logic [3:0] m, logic [7:0] c, logic r48, logic prev);
    logic [127:0] o;
    logic lvl, base, cs, par, b;
    logic [7:0] pat;
    logic [15:0] smp;
    o = '0;
    lvl = prev;
    for (int s = 0; s < 2; s++) begin
      pat = (s == 1) ? 8'b1110_0100 : ((f == 0) ? 8'b1110_1000 : 8'b1110_0010);
      smp = (s == 1) ? r : l;
      cs  = cs_bit(f, m, c, r48);
      par = (^smp) ^ v ^ cs;
      base = lvl;
      for (int k = 0; k < 8; k++) begin
        lvl = pat[7-k] ^ base;
        o[s*64+k] = lvl;
      end
      for (int sl = 4; sl < 32; sl++) begin
        if (sl >= 12 && sl <= 27) b = smp[sl-12];
        else if (sl == 28)        b = v;
        else if (sl == 30)        b = cs;
        else if (sl == 31)        b = par;
        else                      b = 1'b0;
        lvl = ~lvl;
        o[s*64+sl*2] = lvl;
        lvl = lvl ^ b;
        o[s*64+sl*2+1] = lvl;
      end
    end
    return o;
  endfunction

  function automatic string slot_req(int hc, bit uf, bit col);
    int sl;
    sl = (hc % 64) / 2;
    if (sl < 4)              return "R3";
    if (sl < 12)             return "R4";
    if (sl < 28)             return col ? "R7" : (uf ? "R8" : "R2");
    if (sl == 28)            return "R5";
    if (sl == 30)            return "R6";
    return "R4";
  endfunction

  initial begin
    logic [127:0] exp_f;
    logic [31:0]  cur;
    logic [31:0]  q[$];
    logic         last, prev_out, en_q;
    bit           uf, col_frame, col_pend, acc;
    int           hc, frames_done, tbl_i, cyc;

    rst_n = 1'b0; cell_en = 1'b0; s_valid = 1'b0; s_left = '0; s_right = '0;
    validity = 1'b0; rate48 = 1'b1; cs_mode = 4'b1001; cs_cat = 8'hA3;
    repeat (3) @(negedge clk);
    chk(spdif == 1'b0, "R1", "line in reset", 32'(spdif), 0);
    chk(s_ready == 1'b1, "R1", "ready in reset", 32'(s_ready), 1);
    rst_n = 1'b1;
    // R1: first frame is block frame 0 with zero samples
    exp_f = build(0, 16'h0, 16'h0, validity, cs_mode, cs_cat, rate48, 1'b0);
    uf = 1; col_frame = 0; col_pend = 0; hc = 0; frames_done = 0; tbl_i = 0; cyc = 0;
    last = 1'b0;

    while (frames_done < NFRAMES) begin
      cyc++;
      en_q = (cyc % 3 != 0);
      cell_en = en_q;
      acc = 0;
      if (tbl_i < NTBL) begin
        s_valid = 1'b1; {s_left, s_right} = TBL[tbl_i];
        if (s_ready) begin q.push_back(TBL[tbl_i]); tbl_i++; acc = 1; end
      end else if (frames_done == COL_AT && hc == 127 && en_q && s_ready) begin
        // R7: offer a pair exactly on the frame-ending edge
        s_valid = 1'b1; {s_left, s_right} = COL_PAIR;
        q.push_back(COL_PAIR); col_pend = 1; acc = 1;
      end else begin
        s_valid = 1'b0;
      end
      prev_out = spdif;
      @(negedge clk);
      if (en_q) begin
        chk(spdif == exp_f[hc], slot_req(hc, uf, col_frame),
            $sformatf("frame %0d half %0d", frames_done, hc), 32'(spdif), 32'(exp_f[hc]));
        hc++;
        if (hc == 128) begin
          hc = 0;
          last = exp_f[127];
          frames_done++;
          chk(s_ready == 1'b1, "R7", "ready after frame edge", 32'(s_ready), 1);
          if (q.size() > 0) begin
            cur = q.pop_front(); uf = 0; col_frame = col_pend; col_pend = 0;
          end else begin
            cur = '0; uf = 1; col_frame = 0;
          end
          if (frames_done == 3)   validity = 1'b1;
          if (frames_done == 6)   validity = 1'b0;
          if (frames_done == 192) begin rate48 = 1'b0; cs_mode = 4'b0110; cs_cat = 8'h5C; end
          exp_f = build(frames_done % 192, cur[31:16], cur[15:0], validity,
                        cs_mode, cs_cat, rate48, last);
        end else if (acc) begin
          chk(s_ready == 1'b0, "R7", "ready after accept", 32'(s_ready), 0);
        end
      end else begin
        chk(spdif == prev_out, "R9", "line without enable", 32'(spdif), 32'(prev_out));
        if (acc) chk(s_ready == 1'b0, "R7", "ready after accept", 32'(s_ready), 0);
      end
    end
    s_valid = 1'b0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule